// File: doc/BRIEF.md
# Pipelined Rotation-Mode CORDIC with Quadrant Folding

This block turns a signed two-dimensional vector through an arbitrary angle using only shifts and additions. The angle arrives as a two's complement fraction in which the full code range [-1, 1) stands for [-π, π). One new sample can enter every cycle. Each result leaves a fixed number of cycles later, together with the angle error that the micro-rotations left behind. Typical uses are quadrature oscillators, where the input vector is held constant and the phase ramps, and complex mixers, where the vector is the signal and the phase is the carrier.

The micro-rotations only converge for angles of about ±1.74 rad. Angles in the two outer quadrants are therefore moved by half a turn before the rotation, and both output coordinates are negated afterwards. The table of rotation constants is stored already scaled to the phase's own units, so the phase never has to be multiplied by π. An optional final stage removes the CORDIC length growth. It uses a product of five shifted terms, which costs four adders and no multiplier.

Top module: `cordic_rot_top`

## Requirements
- R1: For phase codes whose two most significant bits are equal, each valid result equals the input vector rotated counter-clockwise by phase·π/32768 rad (16-bit phase), scaled by the overall gain, to within 4 output LSBs on both coordinates.
- R2: A phase code whose two most significant bits differ (angles in [π/2, π) and [-π, -π/2)) is folded by half a turn, and both outputs are negated. The result meets the R1 tolerance, including the codes 16384 (π/2), -16384 (-π/2), -32768 (-π) and 32767.
- R3: Every input sample taken with inValid high produces exactly one output with outValid high, exactly LAT = NITER + GAIN_COMP + 2 clock edges later (16 with the defaults).
- R4: Samples presented on consecutive cycles come out on consecutive cycles, in order. Each carries its own fold decision, even when neighbouring samples alternate between folded and unfolded quadrants.
- R5: With GAIN_COMP = 1, the stage multiplies by (1/2)(1+1/4)(1-1/32)(1+1/256)(1-1/1024). The output vector length then matches the input vector length to within 0.2 % plus 3 LSBs.
- R6: While rstN is low, and on the first cycle after it is released, outValid is 0.
- R7: For every valid output, the residual angle outResidual (units of π/2 = 2^16) has a magnitude of at most four times the last micro-rotation constant (40 with the defaults).
- R8: Cycles with inValid low produce no output. Changing inX, inY and inPhase during such cycles does not alter the result of the next valid sample.
- R9: A zero input vector gives exactly zero on both outputs, whatever the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the control pipeline |
| inValid | input | 1 | Sample strobe for inX, inY, inPhase |
| inX | input | 12 | Input vector X, signed |
| inY | input | 12 | Input vector Y, signed |
| inPhase | input | 16 | Rotation angle, signed fraction of π |
| outValid | output | 1 | Result strobe |
| outX | output | 14 | Rotated X, signed |
| outY | output | 14 | Rotated Y, signed |
| outResidual | output | 18 | Leftover angle after the last micro-rotation, signed, π/2 = 65536 |

## Verification
The hardest cases sit on the fold boundary and on streams of mixed samples. Exact ±π/2 and -π decide the fold from a single bit pattern. A folded sample right next to an unfolded one exposes any misalignment of the negate flag with its data. The bench aims directed phase codes at 0x4000, 0xC000, 0x8000 and 0x7FFF. It also sends a back-to-back burst whose phases hop between inner and outer quadrants every cycle, and checks each output against its own ideal rotation.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic loadIn;     // capture a new sample into the entry stage
    logic foldIn;     // the sample being captured lies in an outer quadrant
    logic loadOut;    // load the output register
    logic negateOut;  // the sample entering the output register was folded
  } rotStrobes_t;

  // Micro-rotation angle atan(2^-i) expressed in units of pi/2, scaled by 2^fracBits
  function automatic int alphaUnits(input int i, input int fracBits);
    real a;
    a = $atan(2.0 ** (-i)) * (2.0 / PI_R) * (2.0 ** fracBits);
    return $rtoi(a + 0.5);
  endfunction

endpackage

// File: rtl/cordic_rot_ctrl.sv
module cordic_rot_ctrl
  import cordic_rot_pkg::*;
#(
  parameter int LAT  = 16,
  parameter int NSTG = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        phaseTop,
  output rotStrobes_t       ctl,
  output logic [NSTG-1:0]   stageEn,
  output logic              outValid
);

  logic [LAT-1:0] vld;
  logic [LAT-2:0] fold;
  logic           foldNow;

  // Outer quadrants: the two top phase bits disagree
  assign foldNow = phaseTop[1] ^ phaseTop[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld  <= '0;
      fold <= '0;
    end else begin
      vld  <= {vld[LAT-2:0], inValid};
      fold <= {fold[LAT-3:0], foldNow};
    end
  end

  assign ctl.loadIn    = inValid;
  assign ctl.foldIn    = foldNow;
  assign ctl.loadOut   = vld[LAT-2];
  assign ctl.negateOut = fold[LAT-2];
  assign stageEn       = vld[NSTG-1:0];
  assign outValid      = vld[LAT-1];

  // Occupancy tracker for the sample-conservation checks
  int unsigned inflight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inflight <= 0;
    else       inflight <= inflight + int'(inValid) - int'(outValid);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !outValid); // R6
  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inflight != 0); // R3
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    inflight <= LAT); // R3

endmodule

// File: rtl/cordic_rot_datapath.sv
module cordic_rot_datapath
  import cordic_rot_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int ANG_W     = 16,
  parameter int NITER     = 13,
  parameter int GAIN_COMP = 1,
  parameter int GUARD     = 4,
  parameter int ZG        = 2,
  localparam int IW    = IN_W + 2 + GUARD,
  localparam int ZW    = ANG_W + ZG,
  localparam int OUT_W = IN_W + 2,
  localparam int NSTG  = NITER + GAIN_COMP,
  localparam int FRAC  = ANG_W - 2 + ZG
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rotStrobes_t             ctl,
  input  logic [NSTG-1:0]         stageEn,
  input  logic signed [IN_W-1:0]  inX,
  input  logic signed [IN_W-1:0]  inY,
  input  logic [ANG_W-1:0]        inPhase,
  output logic signed [OUT_W-1:0] outX,
  output logic signed [OUT_W-1:0] outY,
  output logic signed [ZW-1:0]    outResidual
);

  localparam logic signed [ZW-1:0] ZONE = ZW'(2 ** FRAC);

  logic signed [IW-1:0] x0, y0;
  logic signed [ZW-1:0] z0;

  // Entry stage: widen, add guard bits, fold the angle by half a turn (flip MSB)
  always_ff @(posedge clk) begin
    if (ctl.loadIn) begin
      x0 <= {{2{inX[IN_W-1]}}, inX, {GUARD{1'b0}}};
      y0 <= {{2{inY[IN_W-1]}}, inY, {GUARD{1'b0}}};
      z0 <= {inPhase[ANG_W-1] ^ ctl.foldIn, inPhase[ANG_W-2:0], {ZG{1'b0}}};
    end
  end

  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stageEn[0] |-> (z0 <= ZONE && z0 >= -ZONE)); // R2

  for (genvar i = 0; i < NITER; i++) begin : g_iter
    localparam logic signed [ZW-1:0] ALPHA = ZW'(alphaUnits(i, FRAC));
    logic signed [IW-1:0] xPrev, yPrev, xr, yr;
    logic signed [ZW-1:0] zPrev, zr;
    if (i == 0) begin : g_first
      assign xPrev = x0;
      assign yPrev = y0;
      assign zPrev = z0;
    end else begin : g_next
      assign xPrev = g_iter[i-1].xr;
      assign yPrev = g_iter[i-1].yr;
      assign zPrev = g_iter[i-1].zr;
    end
    always_ff @(posedge clk) begin
      if (stageEn[i]) begin
        if (!zPrev[ZW-1]) begin
          xr <= xPrev - (yPrev >>> i);
          yr <= yPrev + (xPrev >>> i);
          zr <= zPrev - ALPHA;
        end else begin
          xr <= xPrev + (yPrev >>> i);
          yr <= yPrev - (xPrev >>> i);
          zr <= zPrev + ALPHA;
        end
      end
    end
  end

  logic signed [IW-1:0] xg, yg;
  logic signed [ZW-1:0] zg;

  function automatic logic signed [IW-1:0] invGain(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] a, b, c, d;
    a = v >>> 1;
    b = a + (a >>> 2);
    c = b - (b >>> 5);
    d = c + (c >>> 8);
    return d - (d >>> 10);
  endfunction

  if (GAIN_COMP != 0) begin : g_gain
    always_ff @(posedge clk) begin
      if (stageEn[NITER]) begin
        xg <= invGain(g_iter[NITER-1].xr);
        yg <= invGain(g_iter[NITER-1].yr);
        zg <= g_iter[NITER-1].zr;
      end
    end
  end else begin : g_nogain
    assign xg = g_iter[NITER-1].xr;
    assign yg = g_iter[NITER-1].yr;
    assign zg = g_iter[NITER-1].zr;
  end

  logic signed [IW-1:0]    xs, ys;
  logic signed [OUT_W-1:0] xt, yt;
  assign xs = xg >>> GUARD;
  assign ys = yg >>> GUARD;
  assign xt = xs[OUT_W-1:0];
  assign yt = ys[OUT_W-1:0];

  // Output stage: undo the fold by negating both coordinates
  always_ff @(posedge clk) begin
    if (ctl.loadOut) begin
      outX        <= ctl.negateOut ? -xt : xt;
      outY        <= ctl.negateOut ? -yt : yt;
      outResidual <= zg;
    end
  end

endmodule

// File: rtl/cordic_rot_top.sv
module cordic_rot_top
  import cordic_rot_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int ANG_W     = 16,
  parameter int NITER     = 13,
  parameter int GAIN_COMP = 1,
  localparam int GUARD = $clog2(NITER),
  localparam int ZG    = 2,
  localparam int ZW    = ANG_W + ZG,
  localparam int OUT_W = IN_W + 2,
  localparam int NSTG  = NITER + GAIN_COMP,
  localparam int LAT   = NSTG + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inX,
  input  logic signed [IN_W-1:0]  inY,
  input  logic [ANG_W-1:0]        inPhase,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outX,
  output logic signed [OUT_W-1:0] outY,
  output logic signed [ZW-1:0]    outResidual
);

  localparam int RES_BOUND = 4 * alphaUnits(NITER - 1, ANG_W - 2 + ZG);

  rotStrobes_t     ctl;
  logic [NSTG-1:0] stageEn;

  cordic_rot_ctrl #(.LAT(LAT), .NSTG(NSTG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .phaseTop (inPhase[ANG_W-1:ANG_W-2]),
    .ctl      (ctl),
    .stageEn  (stageEn),
    .outValid (outValid)
  );

  cordic_rot_datapath #(
    .IN_W(IN_W), .ANG_W(ANG_W), .NITER(NITER),
    .GAIN_COMP(GAIN_COMP), .GUARD(GUARD), .ZG(ZG)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stageEn     (stageEn),
    .inX         (inX),
    .inY         (inY),
    .inPhase     (inPhase),
    .outX        (outX),
    .outY        (outY),
    .outResidual (outResidual)
  );

  AST_OUT_RESIDUAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outResidual <= ZW'(RES_BOUND) && outResidual >= -ZW'(RES_BOUND))); // R7

endmodule

// File: tb/cordic_rot_top_bench.sv
`timescale 1ns/1ps
module cordic_rot_top_bench;

  localparam int  IN_W = 12, ANG_W = 16, NITER = 13, GAIN_COMP = 1;
  localparam int  OUT_W = IN_W + 2, ZW = ANG_W + 2;
  localparam int  LAT = NITER + GAIN_COMP + 2;
  localparam real PI = 3.14159265358979323846;
  localparam real TOL = 4.0;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic signed [IN_W-1:0] inX = '0, inY = '0;
  logic [ANG_W-1:0] inPhase = '0;
  logic outValid;
  logic signed [OUT_W-1:0] outX, outY;
  logic signed [ZW-1:0] outResidual;

  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  cordic_rot_top #(.IN_W(IN_W), .ANG_W(ANG_W), .NITER(NITER), .GAIN_COMP(GAIN_COMP)) u_cordic_rot_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inX(inX), .inY(inY), .inPhase(inPhase),
    .outValid(outValid), .outX(outX), .outY(outY), .outResidual(outResidual));

  function automatic real gainTotal();
    real k = 1.0;
    for (int i = 0; i < NITER; i++) k = k * $sqrt(1.0 + 2.0 ** (-2 * i));
    if (GAIN_COMP != 0)
      k = k * 0.5 * 1.25 * (1.0 - 1.0/32) * (1.0 + 1.0/256) * (1.0 - 1.0/1024);
    return k;
  endfunction

  function automatic int resBound();
    return 4 * $rtoi($atan(2.0 ** (-(NITER - 1))) * (2.0 / PI) * 65536.0 + 0.5);
  endfunction

  function automatic real absr(real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic expectNear(string req, string what, real act, real exp, real tol);
    nChecks++;
    if (absr(act - exp) > tol) begin
      nFail++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  task automatic expectEq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ideal(int x, int y, int ph, output real ex, output real ey);
    real th, g;
    th = real'(ph) * PI / 32768.0;
    g  = gainTotal();
    ex = g * (real'(x) * $cos(th) - real'(y) * $sin(th));
    ey = g * (real'(x) * $sin(th) + real'(y) * $cos(th));
  endtask

  // One isolated sample: latency, value, residual
  task automatic runOne(string req, int x, int y, int ph);
    real ex, ey;
    int cnt;
    @(negedge clk);
    inX = IN_W'(x); inY = IN_W'(y); inPhase = ANG_W'(ph); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    cnt = 1;
    while (!outValid && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    expectEq("R3", "latency", cnt, LAT);
    ideal(x, y, ph, ex, ey);
    expectNear(req, $sformatf("x ph=%0d", ph), real'(int'(outX)), ex, TOL);
    expectNear(req, $sformatf("y ph=%0d", ph), real'(int'(outY)), ey, TOL);
    nChecks++;
    if (int'(outResidual) > resBound() || int'(outResidual) < -resBound()) begin
      nFail++;
      $display("FAIL R7 residual: actual %0d expected |r|<=%0d", int'(outResidual), resBound());
    end
  endtask

  task automatic testReset();
    expectEq("R6", "outValid in reset", int'(outValid), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    expectEq("R6", "outValid after release", int'(outValid), 0);
  endtask

  task automatic testInner();  // R1
    runOne("R1", 2000, 0, 0);
    runOne("R1", 2000, 0, 8192);
    runOne("R1", 2000, 0, -8192);
    runOne("R1", -1500, 900, 12000);
    runOne("R1", 700, -1800, -3000);
  endtask

  task automatic testOuter();  // R2 boundary codes
    runOne("R2", 2000, 0, 16384);
    runOne("R2", 2000, 0, -16384);
    runOne("R2", 2000, 0, -32768);
    runOne("R2", 2000, 0, 32767);
    runOne("R2", 1200, 1300, 24576);
    runOne("R2", -900, 1700, -24576);
  endtask

  task automatic testGainMag();  // R5
    real mi, mo;
    runOne("R5", -2048, -2048, 5000);
    mi = $sqrt(2.0 * 2048.0 * 2048.0);
    mo = $sqrt(real'(int'(outX)) ** 2 + real'(int'(outY)) ** 2);
    expectNear("R5", "magnitude", mo, mi, 0.002 * mi + 3.0);
  endtask

  task automatic testStream();  // R4: alternating quadrants back to back
    int ph[10] = '{3000, 28000, -20000, 10000, -32768, 16384, -16384, 20000, -5000, 31000};
    int xs[10] = '{1900, -1000, 500, 2000, 1500, -2000, 800, 1100, -700, 1300};
    int ys[10] = '{0, 400, -1600, 300, -900, 0, 1800, -1100, -1500, 1000};
    real ex, ey;
    int got = 0;
    for (int c = 0; c < 10 + LAT + 2; c++) begin
      @(negedge clk);
      if (outValid) begin
        expectEq("R4", "output slot", c, got + LAT);
        if (got < 10) begin
          ideal(xs[got], ys[got], ph[got], ex, ey);
          expectNear("R4", $sformatf("stream x%0d", got), real'(int'(outX)), ex, TOL);
          expectNear("R4", $sformatf("stream y%0d", got), real'(int'(outY)), ey, TOL);
        end
        got++;
      end
      if (c < 10) begin
        inX = IN_W'(xs[c]); inY = IN_W'(ys[c]); inPhase = ANG_W'(ph[c]); inValid = 1'b1;
      end else inValid = 1'b0;
    end
    expectEq("R4", "output count", got, 10);
  endtask

  task automatic testIdle();  // R8
    int seen = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      inValid = 1'b0;
      inX = IN_W'(c * 97 - 1400); inY = IN_W'(1000 - c * 61); inPhase = ANG_W'(c * 2111);
      if (outValid) seen++;
    end
    expectEq("R8", "outputs while idle", seen, 0);
    runOne("R8", 1600, -400, -12000);
  endtask

  task automatic testZero();  // R9
    for (int k = 0; k < 3; k++) begin
      runOne("R9", 0, 0, k * 20000 - 25000);
      expectEq("R9", "zero x", int'(outX), 0);
      expectEq("R9", "zero y", int'(outY), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testInner();
    testOuter();
    testGainMag();
    testStream();
    testIdle();
    testZero();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule